// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Priority Unit

This unit collects interrupt requests from a row of device slots on a shared backplane. Each slot supplies its own request level (one of four) and its own vector. The unit keeps a pending flag per slot and presents one winning request to the processor. The winner is the highest level that exceeds the processor's current priority. Among requests at that level, the slot with the lowest index wins, which models position along a daisy chain from the processor end of the bus.

The processor fetches the interrupt through an acknowledge handshake. It raises `iack_i` and the unit latches the winner. The unit then answers with `reply_o` and the winner's vector on `vec_o`, and clears that slot's pending flag. The reply is held until the processor drops `iack_i`. If no request qualifies when the acknowledge starts, the unit never answers, and the processor's own timeout takes over.

Top module: `vint_prio_unit`

## Requirements
- R1: Each slot's level is a 2-bit field of `slot_lvl_i` (slot k at bits 2k+1:2k). A larger value outranks a smaller one, so a qualified request at level 3 beats any qualified request at levels 2 or 1, whatever its slot.
- R2: Among qualified requests at the same winning level, the lowest slot index wins.
- R3: A pending request is qualified only when its level is strictly greater than `cpu_lvl_i`. A level-0 request is therefore never presented, and raising `cpu_lvl_i` masks requests without clearing them.
- R4: `irq_o` is high in the same cycle as any qualified pending request. `irq_lvl_o` shows the winner's level, and is 0 when `irq_o` is low.
- R5: If `iack_i` is seen high in the idle state while a request qualifies, `reply_o` goes high on the next cycle and `vec_o` carries the winning slot's vector (slot k's vector is bits 8k+7:8k of `slot_vec_i`). `vec_o` is 0 whenever `reply_o` is low.
- R6: The winner is fixed on the edge where the acknowledge is accepted. Requests that arrive later, even at a higher level, do not change `vec_o` during that reply.
- R7: A single acknowledge clears only the winning slot's pending flag, and it does so on the accepting edge. Other pending requests stay presented.
- R8: A `req_set_i` pulse takes effect one edge later and sets that slot's pending flag. If the set arrives on the same edge that clears the same slot, the set wins.
- R9: If no request qualifies when `iack_i` is accepted, `reply_o` stays low for as long as `iack_i` is held.
- R10: Asynchronous reset clears all pending flags and drives `irq_o`, `irq_lvl_o`, `reply_o` and `vec_o` to 0.
- R11: `reply_o` stays high while `iack_i` stays high, and falls on the cycle after `iack_i` is seen low. A new acknowledge is accepted only after `iack_i` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | NUM_SLOTS | Per-slot request pulse |
| slot_lvl_i | input | NUM_SLOTS*2 | Per-slot request level |
| slot_vec_i | input | NUM_SLOTS*VEC_W | Per-slot vector |
| cpu_lvl_i | input | 2 | Processor's current priority |
| irq_o | output | 1 | A qualified request is pending |
| irq_lvl_o | output | 2 | Level of the winning request |
| iack_i | input | 1 | Acknowledge request from the processor |
| reply_o | output | 1 | Vector valid reply |
| vec_o | output | VEC_W | Winning vector during reply |

## Verification
Two events can coincide on the accepting edge of an acknowledge: the clear of the winning slot's pending flag, and a new request pulse. The bench provokes this in two ways. In the first, it drives a new request for the same slot in the same cycle as it raises `iack_i`; it then expects the reply to carry that slot's vector and `irq_o` to stay high at the slot's level afterwards. In the second, it raises a higher-level request for a different slot in the accepting cycle; the reply must still carry the earlier winner's vector, while `irq_o` and `irq_lvl_o` already report the newcomer.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int unsigned NUM_LVLS = 4;
  localparam int unsigned LVL_W    = $clog2(NUM_LVLS);

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_REPLY = 2'd1,
    ACK_MUTE  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/vint_pend.sv
module vint_pend #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] set_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  output logic [NUM_SLOTS-1:0] pend_o
);
  logic [NUM_SLOTS-1:0] pend_q;

  // set overrides a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vint_arb.sv
module vint_arb
  import vint_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]       pend_i,
  input  logic [NUM_SLOTS*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]           cpu_lvl_i,
  output logic                       valid_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [LVL_W-1:0]           lvl_o
);
  logic [LVL_W-1:0]                lvl_s [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]            qual;
  logic [NUM_SLOTS-1:0]            cand;
  logic [NUM_SLOTS-1:0]            grant;
  logic [NUM_SLOTS:0]              blk;
  logic [NUM_LVLS-1:0][NUM_SLOTS-1:0] hit;
  logic [NUM_LVLS-1:0]             any_lvl;
  logic [LVL_W-1:0]                top;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign lvl_s[g] = lvl_i[g*LVL_W +: LVL_W];
    assign qual[g]  = pend_i[g] && (lvl_s[g] > cpu_lvl_i);
  end

  for (genvar l = 0; l < NUM_LVLS; l++) begin : g_lvl
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
      assign hit[l][g] = qual[g] && (lvl_s[g] == LVL_W'(l));
    end
    assign any_lvl[l] = |hit[l];
  end

  // highest populated level
  always_comb begin
    top = '0;
    for (int l = 0; l < NUM_LVLS; l++)
      if (any_lvl[l]) top = LVL_W'(l);
  end

  // position chain: first candidate from slot 0 blocks the rest
  assign blk[0] = 1'b0;
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chain
    assign cand[g]   = qual[g] && (lvl_s[g] == top);
    assign grant[g]  = cand[g] && !blk[g];
    assign blk[g+1]  = blk[g] | cand[g];
  end

  always_comb begin
    idx_o = '0;
    for (int g = 0; g < NUM_SLOTS; g++)
      if (grant[g]) idx_o = idx_o | IDX_W'(g);
  end

  assign valid_o = |qual;
  assign lvl_o   = top;
endmodule

// File: rtl/vint_ack.sv
module vint_ack
  import vint_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       iack_i,
  input  logic                       win_valid_i,
  input  logic [IDX_W-1:0]           win_idx_i,
  input  logic [NUM_SLOTS*VEC_W-1:0] slot_vec_i,
  output logic [NUM_SLOTS-1:0]       clr_o,
  output logic                       reply_o,
  output logic [VEC_W-1:0]           vec_o
);
  ack_state_e       state_q, state_d;
  logic [VEC_W-1:0] vec_q;
  logic             accept;

  assign accept = (state_q == ACK_IDLE) && iack_i && win_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE:  if (iack_i) state_d = win_valid_i ? ACK_REPLY : ACK_MUTE;
      ACK_REPLY: if (!iack_i) state_d = ACK_IDLE;
      ACK_MUTE:  if (!iack_i) state_d = ACK_IDLE;
      default:   state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACK_IDLE;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) vec_q <= slot_vec_i[win_idx_i*VEC_W +: VEC_W];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_clr
    assign clr_o[g] = accept && (win_idx_i == IDX_W'(g));
  end

  assign reply_o = (state_q == ACK_REPLY);
  assign vec_o   = reply_o ? vec_q : '0;
endmodule

// File: rtl/vint_prio_unit.sv
module vint_prio_unit
  import vint_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned VEC_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       req_set_i,
  input  logic [NUM_SLOTS*2-1:0]     slot_lvl_i,
  input  logic [NUM_SLOTS*VEC_W-1:0] slot_vec_i,
  input  logic [1:0]                 cpu_lvl_i,
  output logic                       irq_o,
  output logic [1:0]                 irq_lvl_o,
  input  logic                       iack_i,
  output logic                       reply_o,
  output logic [VEC_W-1:0]           vec_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] pend, clr;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;
  logic [LVL_W-1:0]     win_lvl;

  vint_pend #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  vint_arb #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_arb (
    .pend_i    (pend),
    .lvl_i     (slot_lvl_i),
    .cpu_lvl_i (cpu_lvl_i),
    .valid_o   (win_valid),
    .idx_o     (win_idx),
    .lvl_o     (win_lvl)
  );

  vint_ack #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iack_i      (iack_i),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .slot_vec_i  (slot_vec_i),
    .clr_o       (clr),
    .reply_o     (reply_o),
    .vec_o       (vec_o)
  );

  assign irq_o     = win_valid;
  assign irq_lvl_o = win_lvl;
endmodule

// File: rtl/vint_prio_chk.sv
module vint_prio_chk #(
  parameter int unsigned VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cpu_lvl_i,
  input logic             irq_o,
  input logic [1:0]       irq_lvl_o,
  input logic             iack_i,
  input logic             reply_o,
  input logic [VEC_W-1:0] vec_o
);
  // R3
  irq_above_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o > cpu_lvl_i));

  // R4
  idle_lvl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == 2'd0));

  // R5
  vec_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reply_o |-> (vec_o == '0));

  // R5
  ack_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(iack_i) && irq_o) |=> reply_o);

  // R6
  vec_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_o && $past(reply_o)) |-> $stable(vec_o));

  // R9
  no_winner_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(iack_i) && !irq_o) |=> !reply_o);

  // R11
  reply_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_o && !iack_i) |=> !reply_o);

  // R11
  reply_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reply_o) |-> $past(iack_i));
endmodule

bind vint_prio_unit vint_prio_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_lvl_i (cpu_lvl_i),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .iack_i    (iack_i),
  .reply_o   (reply_o),
  .vec_o     (vec_o)
);

// File: tb/sim_vint_prio_unit.sv
module sim_vint_prio_unit;
  localparam int N  = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_set = '0;
  logic [N*2-1:0] slot_lvl;
  logic [N*VW-1:0] slot_vec;
  logic [1:0]    cpu_lvl = 2'd0;
  logic          irq;
  logic [1:0]    irq_lvl;
  logic          iack = 1'b0;
  logic          reply;
  logic [VW-1:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [1:0] LV [N] = '{2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1, 2'd3};

  function automatic logic [VW-1:0] vexp(int s);
    return VW'(8'h80 | (s * 5));
  endfunction

  typedef struct packed {
    logic [7:0] set;
    logic [1:0] cpu;
    logic       exp;
    logic [2:0] slot;
  } row_t;

  localparam row_t TBL [8] = '{
    '{8'b0000_0001, 2'd0, 1'b1, 3'd0},  // R1
    '{8'b1000_0010, 2'd0, 1'b1, 3'd7},  // R1 level beats position
    '{8'b1000_1000, 2'd0, 1'b1, 3'd3},  // R2
    '{8'b0010_0100, 2'd0, 1'b1, 3'd2},  // R2
    '{8'b0001_0000, 2'd0, 1'b0, 3'd0},  // R3 level 0
    '{8'b0000_0110, 2'd2, 1'b0, 3'd0},  // R3 masked
    '{8'b0100_0100, 2'd1, 1'b1, 3'd2},  // R3 partial mask
    '{8'b0000_1001, 2'd2, 1'b1, 3'd0}   // R2 under mask
  };

  vint_prio_unit #(.NUM_SLOTS(N), .VEC_W(VW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .slot_lvl_i(slot_lvl),
    .slot_vec_i(slot_vec), .cpu_lvl_i(cpu_lvl), .irq_o(irq), .irq_lvl_o(irq_lvl),
    .iack_i(iack), .reply_o(reply), .vec_o(vec)
  );

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // full acknowledge; returns vector seen, checks hold
  task automatic do_ack(output logic [VW-1:0] got);
    @(negedge clk) iack = 1'b1;
    @(negedge clk);
    got = vec;
    chk(reply == 1'b1, "R5 reply", int'(reply), 1);
    @(negedge clk);
    chk(reply == 1'b1 && vec == got, "R11 reply hold", int'(vec), int'(got));
    iack = 1'b0;
    @(negedge clk);
    chk(reply == 1'b0 && vec == '0, "R11 release", int'(reply), 0);
  endtask

  task automatic drain();
    logic [VW-1:0] v;
    cpu_lvl = 2'd0;
    for (int k = 0; k < 2*N && irq; k++) do_ack(v);
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk) req_set = m;
    @(negedge clk) req_set = '0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] v;
    for (int s = 0; s < N; s++) begin
      slot_lvl[s*2 +: 2]   = LV[s];
      slot_vec[s*VW +: VW] = vexp(s);
    end
    #5;
    chk(irq == 0 && reply == 0 && vec == 0 && irq_lvl == 0, "R10 reset", int'(irq), 0);
    #50 rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0 && reply == 0, "R10 after release", int'(irq), 0);

    // table walk
    foreach (TBL[t]) begin
      cpu_lvl = TBL[t].cpu;
      pulse(TBL[t].set);
      chk(irq == TBL[t].exp, "R1 R2 R3 R4 irq", int'(irq), int'(TBL[t].exp));
      if (TBL[t].exp) begin
        chk(irq_lvl == LV[TBL[t].slot], "R4 level", int'(irq_lvl), int'(LV[TBL[t].slot]));
        do_ack(v);
        chk(v == vexp(TBL[t].slot), "R1 R2 R5 vector", int'(v), int'(vexp(TBL[t].slot)));
      end else begin
        chk(irq_lvl == 2'd0, "R4 idle level", int'(irq_lvl), 0);
      end
      drain();
    end
    // slot 4 (level 0) remains pending but never presented
    chk(irq == 0, "R3 level 0 never presented", int'(irq), 0);

    // R3: masking keeps request pending
    cpu_lvl = 2'd3;
    pulse(8'b0000_0010);
    chk(irq == 0, "R3 masked", int'(irq), 0);
    @(negedge clk) cpu_lvl = 2'd0;
    #1 chk(irq == 1 && irq_lvl == 2'd1, "R3 unmask", int'(irq_lvl), 1);
    drain();

    // R9: acknowledge with nothing qualified
    @(negedge clk) iack = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(reply == 0 && vec == 0, "R9 no reply", int'(reply), 0);
    end
    iack = 1'b0;
    @(negedge clk);

    // R6: higher request arrives on the accepting edge
    pulse(8'b0000_0010);
    @(negedge clk) begin iack = 1'b1; req_set = 8'b0000_0001; end
    @(negedge clk) req_set = '0;
    chk(reply == 1 && vec == vexp(1), "R6 latched vector", int'(vec), int'(vexp(1)));
    chk(irq == 1 && irq_lvl == 2'd3, "R6 newcomer presented", int'(irq_lvl), 3);
    @(negedge clk) iack = 1'b0;
    @(negedge clk);
    drain();

    // R8: set and clear of same slot on one edge
    pulse(8'b0000_0100);
    @(negedge clk) begin iack = 1'b1; req_set = 8'b0000_0100; end
    @(negedge clk) req_set = '0;
    chk(reply == 1 && vec == vexp(2), "R8 reply vector", int'(vec), int'(vexp(2)));
    chk(irq == 1 && irq_lvl == 2'd2, "R8 set wins", int'(irq), 1);
    @(negedge clk) iack = 1'b0;
    @(negedge clk);
    drain();

    // R7: only winner cleared
    pulse(8'b0000_1001);
    do_ack(v);
    chk(v == vexp(0), "R7 first winner", int'(v), int'(vexp(0)));
    chk(irq == 1 && irq_lvl == 2'd3, "R7 other still pending", int'(irq), 1);
    do_ack(v);
    chk(v == vexp(3), "R7 second winner", int'(v), int'(vexp(3)));
    chk(irq == 0, "R7 drained", int'(irq), 0);

    // R11: back-to-back needs iack low in between; holding iack gives one service
    pulse(8'b1000_0001);
    @(negedge clk) iack = 1'b1;
    repeat (4) @(negedge clk);
    chk(reply == 1 && vec == vexp(0), "R11 single service", int'(vec), int'(vexp(0)));
    chk(irq == 1, "R11 second still pending", int'(irq), 1);
    iack = 1'b0;
    @(negedge clk);
    drain();

    // R10: reset mid-run clears pending
    pulse(8'b0000_0001);
    @(negedge clk) rst_n = 1'b0;
    #1 chk(irq == 0 && reply == 0, "R10 async clear", int'(irq), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0, "R10 stays clear", int'(irq), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule